// File: doc/BRIEF.md
# Repeated-Frame Serial Bit Transmitter

This block turns one short record of payload bytes into a framed serial bitstream and sends that frame three times in a row. Each frame has four fields with no gap between them: a fixed idle preamble, a fixed start marker, the payload bits, and a fixed tail marker. The first pass sends every bit of the frame inverted, the second pass sends it unmodified, and the third pass inverts it again. Only after the third pass does the block take another record.

A producer offers a record with a valid/ready handshake. The record carries up to four bytes and a byte count. The block keeps the record internally for all three passes. One output bit is produced for every cycle in which the bit-enable input is high, so the line rate is set by the caller. Alongside each bit the block shows which pass the bit belongs to. A one-cycle pulse marks the last bit of the record.

Top module: `rfx_serial_tx`

## Requirements
- R1: Every frame is the idle field 010, then the start field 1110, then the payload, then the tail field 11000, each fixed field sent leftmost bit first, with no idle bit between fields.
- R2: Payload byte 0 sits in rec_data[7:0], byte 1 in rec_data[15:8] and so on. Bytes go out in ascending order, each most significant bit first, and exactly the counted number of bytes is sent.
- R3: A rec_count of 0 sends one byte. A rec_count above 4 sends four bytes. Otherwise rec_count bytes are sent, so a frame is 12 + 8 × bytes bits long.
- R4: Each record goes out as three consecutive passes of the same frame: pass 1 with every bit inverted, pass 2 unmodified, pass 3 inverted. All passes use the data latched at acceptance.
- R5: While ser_valid is high, pass_idx gives the pass (1, 2 or 3) of the bit on ser_bit. pass_idx becomes 1 in the cycle after a record is accepted and is 1 after reset.
- R6: A record is accepted at a clock edge where rec_valid and rec_ready are both high. rec_ready is low from the next cycle until the final bit is shown. rec_valid offered while rec_ready is low has no effect on the stream.
- R7: ser_valid is high in exactly the cycles that follow a cycle with bit_en high while a record is in progress. ser_bit is 0 whenever ser_valid is low.
- R8: rec_done is high for exactly one cycle, together with the final tail bit of pass 3. rec_ready rises in that same cycle.
- R9: rst_n low asynchronously abandons any record and forces rec_ready high, ser_valid, ser_bit and rec_done low, and pass_idx to 1. Release takes effect synchronously a few cycles later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_en | input | 1 | Advance one bit this cycle |
| rec_valid | input | 1 | Record offered |
| rec_ready | output | 1 | Block can take a record |
| rec_data | input | 32 | Payload bytes, byte 0 in the low byte |
| rec_count | input | 3 | Number of payload bytes |
| ser_bit | output | 1 | Serial output bit |
| ser_valid | output | 1 | ser_bit carries a frame bit this cycle |
| pass_idx | output | 2 | Pass number of the shown bit |
| rec_done | output | 1 | Final bit of the record |

## Verification
The hardest case to reach from the ports is a pass boundary that coincides with a gap in bit_en. In that case the pass counter has to advance on the tail bit and then hold through the idle cycles without repeating or skipping a bit. The bench drives three enable patterns: always on, every other cycle, and two of every three cycles. It compares all three passes bit for bit against a frame model built from the requirements, so each boundary is crossed with both enabled and disabled neighbour cycles. Separate stimulus covers two more cases: a new record offered while a record is in progress, and a reset in the middle of a pass.

// File: rtl/rfx_pkg.sv
package rfx_pkg;

  typedef enum logic [1:0] {
    FLD_IDLE  = 2'd0,
    FLD_START = 2'd1,
    FLD_PAY   = 2'd2,
    FLD_TAIL  = 2'd3
  } fld_e;

  localparam int IDLE_LEN  = 3;
  localparam int START_LEN = 4;
  localparam int TAIL_LEN  = 5;
  localparam int NUM_PASS  = 3;
  localparam int PASS_W    = 2;

  localparam logic [IDLE_LEN-1:0]  IDLE_PAT  = 3'b010;
  localparam logic [START_LEN-1:0] START_PAT = 4'b1110;
  localparam logic [TAIL_LEN-1:0]  TAIL_PAT  = 5'b11000;

  // Pass 2 is the only pass sent without inversion
  function automatic logic pass_inverts(input logic [PASS_W-1:0] pass);
    return pass != PASS_W'(2);
  endfunction

endpackage

// File: rtl/rfx_rst_sync.sv
module rfx_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_n_sync = sync_q[STAGES-1];

endmodule

// File: rtl/rfx_rec_latch.sv
module rfx_rec_latch #(
  parameter  int MAX_BYTES = 4,
  parameter  int CNT_W     = 3,
  localparam int DATA_W    = MAX_BYTES * 8,
  localparam int NB_W      = $clog2(MAX_BYTES + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rec_valid,
  input  logic [DATA_W-1:0] rec_data,
  input  logic [CNT_W-1:0]  rec_count,
  input  logic              finish,
  output logic              accept,
  output logic              busy,
  output logic [DATA_W-1:0] data_q,
  output logic [NB_W-1:0]   nbytes_q
);

  logic            busy_q;
  logic            busy_d;
  logic [NB_W-1:0] nb_in;

  // Clamp the requested count into 1..MAX_BYTES
  always_comb begin
    if (rec_count == '0) begin
      nb_in = NB_W'(1);
    end else if (int'(rec_count) > MAX_BYTES) begin
      nb_in = NB_W'(MAX_BYTES);
    end else begin
      nb_in = NB_W'(rec_count);
    end
  end

  always_comb begin
    accept = rec_valid && !busy_q;
    busy_d = busy_q;
    if (accept) begin
      busy_d = 1'b1;
    end else if (finish) begin
      busy_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
    end else begin
      busy_q <= busy_d;
    end
  end

  // Payload storage needs no reset: it is written before it is read
  always_ff @(posedge clk) begin
    if (accept) begin
      data_q   <= rec_data;
      nbytes_q <= nb_in;
    end
  end

  assign busy = busy_q;

endmodule

// File: rtl/rfx_frame_seq.sv
module rfx_frame_seq
  import rfx_pkg::*;
#(
  parameter  int MAX_BYTES = 4,
  localparam int NB_W      = $clog2(MAX_BYTES + 1),
  localparam int IDX_W     = $clog2(MAX_BYTES * 8)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  logic              step,
  input  logic [NB_W-1:0]   nbytes,
  output fld_e              fld_q,
  output logic [IDX_W-1:0]  idx_q,
  output logic [PASS_W-1:0] pass_q,
  output logic              last_bit
);

  fld_e              fld_d;
  logic [IDX_W-1:0]  idx_d;
  logic [PASS_W-1:0] pass_d;
  logic              field_last;
  logic [NB_W+2:0]   pay_bits;
  logic [IDX_W-1:0]  pay_last_idx;
  logic              seq_en;

  always_comb begin
    pay_bits     = {nbytes, 3'b000};
    pay_last_idx = IDX_W'(pay_bits - 1'b1);
    unique case (fld_q)
      FLD_IDLE:  field_last = (idx_q == IDX_W'(IDLE_LEN - 1));
      FLD_START: field_last = (idx_q == IDX_W'(START_LEN - 1));
      FLD_PAY:   field_last = (idx_q == pay_last_idx);
      FLD_TAIL:  field_last = (idx_q == IDX_W'(TAIL_LEN - 1));
      default:   field_last = 1'b1;
    endcase
    last_bit = (fld_q == FLD_TAIL) && field_last && (pass_q == PASS_W'(NUM_PASS));
  end

  always_comb begin
    seq_en = accept || step;
    fld_d  = fld_q;
    idx_d  = idx_q;
    pass_d = pass_q;
    if (accept) begin
      fld_d  = FLD_IDLE;
      idx_d  = '0;
      pass_d = PASS_W'(1);
    end else if (step) begin
      if (field_last) begin
        idx_d = '0;
        unique case (fld_q)
          FLD_IDLE:  fld_d = FLD_START;
          FLD_START: fld_d = FLD_PAY;
          FLD_PAY:   fld_d = FLD_TAIL;
          default: begin
            fld_d  = FLD_IDLE;
            pass_d = (pass_q == PASS_W'(NUM_PASS)) ? PASS_W'(1) : pass_q + PASS_W'(1);
          end
        endcase
      end else begin
        idx_d = idx_q + IDX_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fld_q  <= FLD_IDLE;
      idx_q  <= '0;
      pass_q <= PASS_W'(1);
    end else if (seq_en) begin
      fld_q  <= fld_d;
      idx_q  <= idx_d;
      pass_q <= pass_d;
    end
  end

endmodule

// File: rtl/rfx_bit_out.sv
module rfx_bit_out
  import rfx_pkg::*;
#(
  parameter  int MAX_BYTES = 4,
  localparam int DATA_W    = MAX_BYTES * 8,
  localparam int IDX_W     = $clog2(MAX_BYTES * 8)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  logic              step,
  input  fld_e              fld,
  input  logic [IDX_W-1:0]  idx,
  input  logic [PASS_W-1:0] pass,
  input  logic              last_bit,
  input  logic [DATA_W-1:0] data,
  output logic              ser_bit,
  output logic              ser_valid,
  output logic [PASS_W-1:0] pass_idx,
  output logic              rec_done
);

  logic              raw_bit;
  logic              line_bit;
  logic [IDX_W-1:0]  pay_pos;
  logic              sb_d;
  logic              sv_d;
  logic              dn_d;
  logic [PASS_W-1:0] pi_d;
  logic              sb_q;
  logic              sv_q;
  logic              dn_q;
  logic [PASS_W-1:0] pi_q;

  // Byte index in the upper bits, MSB-first bit in the low three
  always_comb begin
    pay_pos = {idx[IDX_W-1:3], ~idx[2:0]};
    unique case (fld)
      FLD_IDLE:  raw_bit = IDLE_PAT[2'(IDLE_LEN - 1) - idx[1:0]];
      FLD_START: raw_bit = START_PAT[~idx[1:0]];
      FLD_PAY:   raw_bit = data[pay_pos];
      FLD_TAIL:  raw_bit = TAIL_PAT[3'(TAIL_LEN - 1) - idx[2:0]];
      default:   raw_bit = 1'b0;
    endcase
    line_bit = raw_bit ^ pass_inverts(pass);
  end

  always_comb begin
    sv_d = step;
    sb_d = step && line_bit;
    dn_d = step && last_bit;
    pi_d = pi_q;
    if (accept) begin
      pi_d = PASS_W'(1);
    end else if (step) begin
      pi_d = pass;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sv_q <= 1'b0;
      sb_q <= 1'b0;
      dn_q <= 1'b0;
      pi_q <= PASS_W'(1);
    end else begin
      sv_q <= sv_d;
      sb_q <= sb_d;
      dn_q <= dn_d;
      if (accept || step) begin
        pi_q <= pi_d;
      end
    end
  end

  assign ser_bit   = sb_q;
  assign ser_valid = sv_q;
  assign rec_done  = dn_q;
  assign pass_idx  = pi_q;

endmodule

// File: rtl/rfx_serial_tx.sv
module rfx_serial_tx
  import rfx_pkg::*;
#(
  parameter  int MAX_BYTES   = 4,
  parameter  int CNT_W       = 3,
  parameter  int RST_STAGES  = 2,
  localparam int DATA_W      = MAX_BYTES * 8,
  localparam int NB_W        = $clog2(MAX_BYTES + 1),
  localparam int IDX_W       = $clog2(MAX_BYTES * 8)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_en,
  input  logic              rec_valid,
  output logic              rec_ready,
  input  logic [DATA_W-1:0] rec_data,
  input  logic [CNT_W-1:0]  rec_count,
  output logic              ser_bit,
  output logic              ser_valid,
  output logic [1:0]        pass_idx,
  output logic              rec_done
);

  logic              rst_n_int;
  logic              accept;
  logic              busy;
  logic              step;
  logic              last_bit;
  logic [DATA_W-1:0] data_q;
  logic [NB_W-1:0]   nbytes_q;
  fld_e              fld_q;
  logic [IDX_W-1:0]  idx_q;
  logic [PASS_W-1:0] pass_q;

  rfx_rst_sync #(
    .STAGES (RST_STAGES)
  ) rst_sync_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_int)
  );

  rfx_rec_latch #(
    .MAX_BYTES (MAX_BYTES),
    .CNT_W     (CNT_W)
  ) rec_latch_i (
    .clk       (clk),
    .rst_n     (rst_n_int),
    .rec_valid (rec_valid),
    .rec_data  (rec_data),
    .rec_count (rec_count),
    .finish    (step && last_bit),
    .accept    (accept),
    .busy      (busy),
    .data_q    (data_q),
    .nbytes_q  (nbytes_q)
  );

  assign step      = busy && bit_en;
  assign rec_ready = !busy;

  rfx_frame_seq #(
    .MAX_BYTES (MAX_BYTES)
  ) frame_seq_i (
    .clk      (clk),
    .rst_n    (rst_n_int),
    .accept   (accept),
    .step     (step),
    .nbytes   (nbytes_q),
    .fld_q    (fld_q),
    .idx_q    (idx_q),
    .pass_q   (pass_q),
    .last_bit (last_bit)
  );

  rfx_bit_out #(
    .MAX_BYTES (MAX_BYTES)
  ) bit_out_i (
    .clk       (clk),
    .rst_n     (rst_n_int),
    .accept    (accept),
    .step      (step),
    .fld       (fld_q),
    .idx       (idx_q),
    .pass      (pass_q),
    .last_bit  (last_bit),
    .data      (data_q),
    .ser_bit   (ser_bit),
    .ser_valid (ser_valid),
    .pass_idx  (pass_idx),
    .rec_done  (rec_done)
  );

endmodule

// File: rtl/rfx_serial_tx_chk.sv
module rfx_serial_tx_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       bit_en,
  input logic       rec_ready,
  input logic       ser_bit,
  input logic       ser_valid,
  input logic [1:0] pass_idx,
  input logic       rec_done
);

  // R7
  quiet_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ser_valid |-> !ser_bit);

  // R7
  bit_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ser_valid |-> $past(bit_en));

  // R8
  done_with_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rec_done |-> (ser_valid && rec_ready));

  // R8
  done_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rec_done |=> !rec_done);

  // R4
  final_tail_inverted_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rec_done |-> (ser_bit && pass_idx == 2'd3));

  // R6
  ready_rise_at_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rec_ready) |-> rec_done);

  // R5
  pass_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pass_idx != 2'd0);

endmodule

bind rfx_serial_tx rfx_serial_tx_chk chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .bit_en    (bit_en),
  .rec_ready (rec_ready),
  .ser_bit   (ser_bit),
  .ser_valid (ser_valid),
  .pass_idx  (pass_idx),
  .rec_done  (rec_done)
);

// File: tb/rfx_serial_tx_tb_top.sv
module rfx_serial_tx_tb_top;

  typedef struct packed {
    logic [2:0]  cnt;
    logic [2:0]  nb;      // expected byte count after clamping
    logic [31:0] data;
    logic [1:0]  mode;    // 0 always, 1 every other cycle, 2 two of three
    logic        intrude; // offer another record mid-stream
  } vec_t;

  localparam int NVEC = 6;
  localparam vec_t VECS [NVEC] = '{
    '{3'd2, 3'd2, 32'h0000_00AA, 2'd0, 1'b0},
    '{3'd2, 3'd2, 32'h0000_11BB, 2'd1, 1'b0},
    '{3'd0, 3'd1, 32'hFFFF_FF5A, 2'd2, 1'b0},
    '{3'd4, 3'd4, 32'h1234_5678, 2'd0, 1'b1},
    '{3'd7, 3'd4, 32'hC3A5_0F81, 2'd1, 1'b0},
    '{3'd3, 3'd3, 32'hFF00_80FE, 2'd2, 1'b1}
  };

  logic        clk;
  logic        rst_n;
  logic        bit_en;
  logic        rec_valid;
  logic        rec_ready;
  logic [31:0] rec_data;
  logic [2:0]  rec_count;
  logic        ser_bit;
  logic        ser_valid;
  logic [1:0]  pass_idx;
  logic        rec_done;

  int checks = 0;
  int fails  = 0;

  rfx_serial_tx dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .bit_en    (bit_en),
    .rec_valid (rec_valid),
    .rec_ready (rec_ready),
    .rec_data  (rec_data),
    .rec_count (rec_count),
    .ser_bit   (ser_bit),
    .ser_valid (ser_valid),
    .pass_idx  (pass_idx),
    .rec_done  (rec_done)
  );

  initial clk = 1'b0;
  always #4ns clk = ~clk;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  // Frame model taken from the requirements
  function automatic int build(input logic [31:0] d, input int nb, output logic [0:191] s);
    logic [2:0] ip;
    logic [3:0] sp;
    logic [4:0] tp;
    int n;
    logic inv;
    ip = 3'b010;
    sp = 4'b1110;
    tp = 5'b11000;
    n = 0;
    s = '0;
    for (int p = 1; p <= 3; p++) begin
      inv = (p != 2);
      for (int i = 2; i >= 0; i--) begin s[n] = ip[i] ^ inv; n++; end
      for (int i = 3; i >= 0; i--) begin s[n] = sp[i] ^ inv; n++; end
      for (int b = 0; b < nb; b++) begin
        for (int i = 7; i >= 0; i--) begin s[n] = d[b*8 + i] ^ inv; n++; end
      end
      for (int i = 4; i >= 0; i--) begin s[n] = tp[i] ^ inv; n++; end
    end
    return n;
  endfunction

  task automatic run_rec(input vec_t v);
    logic [0:191] exp_s;
    logic [0:191] got_s;
    int n, flen, got, cyc, done_at, mism;
    int valerr, zeroerr, passerr, readyerr, doneerr;
    bit prev_en, en, done_seen;
    n = build(v.data, int'(v.nb), exp_s);
    flen = n / 3;
    got_s = '0;
    while (!rec_ready) @(negedge clk);
    rec_data  = v.data;
    rec_count = v.cnt;
    rec_valid = 1'b1;
    bit_en    = 1'b0;
    @(negedge clk);
    rec_valid = 1'b0;
    chk(rec_ready == 1'b0, "R6", "ready after accept", rec_ready, 0);
    chk(pass_idx == 2'd1, "R5", "pass_idx after accept", pass_idx, 1);
    got = 0; cyc = 0; done_at = -1; prev_en = 1'b0; done_seen = 1'b0;
    valerr = 0; zeroerr = 0; passerr = 0; readyerr = 0; doneerr = 0;
    while (!done_seen && cyc < 4000) begin
      if (ser_valid != prev_en) valerr++;
      if (!ser_valid && ser_bit) zeroerr++;
      if (rec_done && !ser_valid) doneerr++;
      if (rec_ready != rec_done) readyerr++;
      if (ser_valid) begin
        if (got < 192) got_s[got] = ser_bit;
        if (int'(pass_idx) != got / flen + 1) passerr++;
        if (rec_done) begin done_at = got; done_seen = 1'b1; end
        got++;
      end
      if (!done_seen) begin
        unique case (v.mode)
          2'd0:    en = 1'b1;
          2'd1:    en = (cyc % 2 == 0);
          default: en = (cyc % 3 != 0);
        endcase
        bit_en  = en;
        prev_en = en;
        rec_valid = v.intrude && got >= 5 && got < 15;
        rec_data  = ~v.data;
        rec_count = 3'd1;
        @(negedge clk);
        cyc++;
      end
    end
    bit_en = 1'b0;
    rec_valid = 1'b0;
    mism = 0;
    for (int i = 0; i < n && i < 192; i++) if (got_s[i] != exp_s[i]) mism++;
    chk(got == 3 * (12 + 8 * int'(v.nb)), "R3", "bits sent for count", got, 3 * (12 + 8 * int'(v.nb)));
    chk(mism == 0, "R1 R2 R4", "mismatching stream bits", mism, 0);
    if (v.intrude) chk(mism == 0 && got == n, "R6", "stream with ignored offer", mism, 0);
    chk(valerr == 0, "R7", "ser_valid vs bit_en errors", valerr, 0);
    chk(zeroerr == 0, "R7", "ser_bit high while idle", zeroerr, 0);
    chk(passerr == 0, "R5", "pass_idx errors", passerr, 0);
    chk(readyerr == 0, "R6", "ready not low in record", readyerr, 0);
    chk(doneerr == 0 && done_at == n - 1, "R8", "done position", done_at, n - 1);
    @(negedge clk);
    chk(rec_done == 1'b0 && ser_valid == 1'b0, "R8", "done one cycle", rec_done, 0);
    chk(rec_ready == 1'b1, "R6", "ready after record", rec_ready, 1);
  endtask

  initial begin
    #1200us;
    checks++;
    fails++;
    $display("FAIL R7 watchdog: actual=%0d expected=%0d", 1, 0);
    summary();
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    bit_en = 1'b0;
    rec_valid = 1'b0;
    rec_data = '0;
    rec_count = '0;
    repeat (3) @(negedge clk);
    // R9 reset state
    chk(rec_ready == 1'b1, "R9", "ready in reset", rec_ready, 1);
    chk(ser_valid == 1'b0 && ser_bit == 1'b0, "R9", "line in reset", ser_valid, 0);
    chk(pass_idx == 2'd1, "R9", "pass_idx in reset", pass_idx, 1);
    chk(rec_done == 1'b0, "R9", "done in reset", rec_done, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    for (int k = 0; k < NVEC; k++) run_rec(VECS[k]);

    // R9 reset in the middle of a record
    while (!rec_ready) @(negedge clk);
    rec_data = 32'hDEAD_BEEF;
    rec_count = 3'd4;
    rec_valid = 1'b1;
    @(negedge clk);
    rec_valid = 1'b0;
    bit_en = 1'b1;
    repeat (10) @(negedge clk);
    rst_n = 1'b0;
    #1ns;
    chk(rec_ready == 1'b1, "R9", "ready on mid reset", rec_ready, 1);
    chk(ser_valid == 1'b0 && ser_bit == 1'b0, "R9", "line on mid reset", ser_valid, 0);
    chk(pass_idx == 2'd1, "R9", "pass_idx on mid reset", pass_idx, 1);
    bit_en = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(ser_valid == 1'b0 && rec_ready == 1'b1, "R9", "idle after release", ser_valid, 0);
    run_rec(VECS[1]);

    summary();
    $finish;
  end

endmodule